// File: doc/BRIEF.md
# Segment Register Load Unit

This unit services requests to place a 16-bit selector into one of six segment registers. On acceptance it splits the selector into a descriptor index, a table-choice bit and a requested privilege level. The table-choice bit picks either the global or the local descriptor table. The unit checks that the whole 8-byte entry lies inside the chosen table's limit and forms the entry address.

The unit then reads the entry through a plain 32-bit read port, one word per handshake. From that entry it fills the cached base, limit and attribute fields that sit behind the visible selector of the target register. Each table's base and limit are written through a small configuration port.

Faults are reported with a code on the completion pulse. A faulting load leaves the target register exactly as it was. A combinational read port shows the full contents of any segment register.

Top module: `seg_load_unit`

## Requirements
- R1: The selector splits into index = bits 15:3, table choice = bit 2 (0 global, 1 local) and RPL = bits 1:0. The first descriptor read goes to the chosen table's base + index*8.
- R2: If index*8+7 is greater than the chosen table's limit, the load completes with fault code 1. It makes no memory read and leaves the register unchanged.
- R3: A descriptor is read as two words, the low word at the entry address and then the high word at that address + 4. A request holds its address steady until `mem_ack` is seen.
- R4: The low word is the segment base. The high word carries limit in bits 19:0, S in bit 20, type in bits 24:21, DPL in bits 26:25 and present in bit 27. A successful load stores the selector, base, limit and attributes {present, DPL, type, S} with valid = 1. The read port shows them from the cycle after `ld_done`.
- R5: A high word with present = 0 gives fault code 2, and the register is unchanged.
- R6: A present descriptor with S = 0 (a system descriptor) gives fault code 3, and the register is unchanged.
- R7: A global-table selector with index 0 completes with code 0 and makes no read. It stores the selector with valid = 0 and zero base, limit and attributes. A local-table selector with index 0 is fetched normally.
- R8: When `cfg_we` is high, `cfg_tbl` (0 global, 1 local) picks which table takes `cfg_base` and `cfg_limit`. Both tables reset to base 0 and limit 0.
- R9: `ld_ready` is high only while idle. A load is taken when `ld_valid` and `ld_ready` are both high and `ld_seg` < 6; values 6 and 7 are ignored. `ld_done` is a one-cycle pulse, and `ld_fault` is 0 whenever `ld_done` is low.
- R10: After reset all six registers read selector 0, valid 0, base 0, limit 0 and attributes 0, and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table configuration write |
| cfg_tbl | input | 1 | Table written: 0 global, 1 local |
| cfg_base | input | 32 | Table base address |
| cfg_limit | input | 16 | Table byte limit |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Target register number 0..5 |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Unit idle, request can be taken |
| ld_done | output | 1 | Load completion pulse |
| ld_fault | output | 2 | Fault code with ld_done: 0 none, 1 limit, 2 absent, 3 system |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| rd_seg | input | 3 | Register number to inspect |
| rd_valid | output | 1 | Inspected register holds a usable descriptor |
| rd_sel | output | 16 | Inspected visible selector |
| rd_base | output | 32 | Inspected cached base |
| rd_limit | output | 20 | Inspected cached limit |
| rd_attr | output | 8 | Inspected attributes {present, DPL, type, S} |

## Verification
The bound checker watches the handshake on every cycle. It checks that requests occur only while busy, that completion is a single pulse with a code only alongside it, and that register numbers 6 and 7 are ignored. It also checks that a pending read holds its address, that the high-word read follows the low word at +4, and that a limit fault finishes without any read. Whether the right table was picked, the decoding of descriptor fields into the cached register, the null selector, and the rule that a faulting load leaves a register untouched can only be seen by the bench. The bench shows these by comparing the read port against its own model after directed and random loads, with a responder that answers after a random delay.

// File: rtl/seg_pkg.sv
`timescale 1ns/1ps
package seg_pkg;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 13;
    localparam int TLIM_W  = 16;
    localparam int SLIM_W  = 20;
    localparam int ATTR_W  = 8;
    localparam int NUM_SEG = 6;
    localparam int SEG_W   = $clog2(NUM_SEG);
    localparam int NUM_TBL = 2;
    localparam int WORD_STEP = 4;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ti;
        logic [1:0]       rpl;
    } sel_t;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic [3:0] typ;
        logic       s;
    } attr_t;

    typedef struct packed {
        sel_t              sel;
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [SLIM_W-1:0] limit;
        attr_t             attr;
    } seg_ent_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [TLIM_W-1:0] limit;
    } tbl_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_LIMIT  = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_SYSTEM = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_LO, ST_HI, ST_DONE
    } fetch_st_e;

    // Entry address: table base plus eight bytes per index.
    function automatic logic [ADDR_W-1:0] desc_addr(tbl_t t, logic [IDX_W-1:0] idx);
        return t.base + ADDR_W'({idx, 3'b000});
    endfunction

    // Last byte of the entry lies beyond the table limit.
    function automatic logic past_limit(tbl_t t, logic [IDX_W-1:0] idx);
        return {idx, 3'b111} > t.limit;
    endfunction

    function automatic attr_t hi_attr(logic [31:0] hi);
        return attr_t'(hi[SLIM_W +: ATTR_W]);
    endfunction

    // Absent outranks system-type.
    function automatic fault_e hi_fault(logic [31:0] hi);
        attr_t a;
        a = hi_attr(hi);
        if (!a.present) return FLT_ABSENT;
        if (!a.s)       return FLT_SYSTEM;
        return FLT_NONE;
    endfunction
endpackage

// File: rtl/seg_tbl_regs.sv
`timescale 1ns/1ps
module seg_tbl_regs
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [TLIM_W-1:0] cfg_limit,
    input  logic              pick_ti,
    output tbl_t              tbl_o
);
    tbl_t tbls [NUM_TBL];

    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (rst) begin
                tbls[g] <= '0;
            end else if (cfg_we && (cfg_tbl == 1'(g))) begin
                tbls[g].base  <= cfg_base;
                tbls[g].limit <= cfg_limit;
            end
        end
    end

    assign tbl_o = pick_ti ? tbls[1] : tbls[0];
endmodule

// File: rtl/seg_sel_check.sv
`timescale 1ns/1ps
module seg_sel_check
    import seg_pkg::*;
(
    input  sel_t              sel,
    input  tbl_t              tbl,
    output logic              is_null,
    output logic              over_lim,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        is_null  = !sel.ti && (sel.idx == '0);
        over_lim = past_limit(tbl, sel.idx);
        addr     = desc_addr(tbl, sel.idx);
    end
endmodule

// File: rtl/seg_fetch_fsm.sv
`timescale 1ns/1ps
module seg_fetch_fsm
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  sel_t              ld_sel,
    input  logic              chk_null,
    input  logic              chk_over,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              ld_ready,
    output logic              ld_done,
    output fault_e            ld_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              wr_en,
    output logic [SEG_W-1:0]  wr_seg,
    output seg_ent_t          wr_ent
);
    fetch_st_e         st;
    logic [SEG_W-1:0]  seg_q;
    sel_t              sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q, hi_q;
    fault_e            flt_q;
    logic              null_q;
    logic              accept;

    assign accept = ld_valid && (st == ST_IDLE) && (ld_seg < SEG_W'(NUM_SEG));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            seg_q  <= '0;
            sel_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            flt_q  <= FLT_NONE;
            null_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (accept) begin
                    seg_q  <= ld_seg;
                    sel_q  <= ld_sel;
                    addr_q <= chk_addr;
                    null_q <= chk_null;
                    if (chk_null) begin
                        flt_q <= FLT_NONE;
                        st    <= ST_DONE;
                    end else if (chk_over) begin
                        flt_q <= FLT_LIMIT;
                        st    <= ST_DONE;
                    end else begin
                        flt_q <= FLT_NONE;
                        st    <= ST_LO;
                    end
                end
                ST_LO: if (mem_ack) begin
                    lo_q <= mem_rdata;
                    st   <= ST_HI;
                end
                ST_HI: if (mem_ack) begin
                    hi_q  <= mem_rdata;
                    flt_q <= hi_fault(mem_rdata);
                    st    <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_ready = (st == ST_IDLE);
        ld_done  = (st == ST_DONE);
        ld_fault = ld_done ? flt_q : FLT_NONE;
        mem_req  = (st == ST_LO) || (st == ST_HI);
        mem_addr = addr_q + ((st == ST_HI) ? ADDR_W'(WORD_STEP) : '0);
        wr_en    = ld_done && (flt_q == FLT_NONE);
        wr_seg   = seg_q;
        wr_ent   = '0;
        wr_ent.sel = sel_q;
        if (!null_q) begin
            wr_ent.valid = 1'b1;
            wr_ent.base  = lo_q;
            wr_ent.limit = hi_q[SLIM_W-1:0];
            wr_ent.attr  = hi_attr(hi_q);
        end
    end
endmodule

// File: rtl/seg_reg_file.sv
`timescale 1ns/1ps
module seg_reg_file
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_seg,
    input  seg_ent_t         wr_ent,
    input  logic [SEG_W-1:0] rd_seg,
    output seg_ent_t         rd_ent
);
    seg_ent_t ents [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (wr_en && (wr_seg == SEG_W'(g)))
                ents[g] <= wr_ent;
        end
    end

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < NUM_SEG; i++)
            if (rd_seg == SEG_W'(i)) rd_ent = ents[i];
    end
endmodule

// File: rtl/seg_load_unit.sv
`timescale 1ns/1ps
module seg_load_unit
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [TLIM_W-1:0] cfg_limit,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [15:0]       ld_sel,
    output logic              ld_ready,
    output logic              ld_done,
    output logic [1:0]        ld_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic              rd_valid,
    output logic [15:0]       rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output logic [SLIM_W-1:0] rd_limit,
    output logic [ATTR_W-1:0] rd_attr
);
    sel_t              sel_in;
    tbl_t              tbl;
    logic              chk_null, chk_over;
    logic [ADDR_W-1:0] chk_addr;
    fault_e            flt;
    logic              wr_en;
    logic [SEG_W-1:0]  wr_seg;
    seg_ent_t          wr_ent, rd_ent;

    assign sel_in = sel_t'(ld_sel);

    seg_tbl_regs u_tbl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .pick_ti(sel_in.ti), .tbl_o(tbl)
    );

    seg_sel_check u_chk_sel (
        .sel(sel_in), .tbl(tbl),
        .is_null(chk_null), .over_lim(chk_over), .addr(chk_addr)
    );

    seg_fetch_fsm u_fsm (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(sel_in),
        .chk_null(chk_null), .chk_over(chk_over), .chk_addr(chk_addr),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_fault(flt),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_seg(wr_seg), .wr_ent(wr_ent)
    );

    seg_reg_file u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_seg(wr_seg), .wr_ent(wr_ent),
        .rd_seg(rd_seg), .rd_ent(rd_ent)
    );

    assign ld_fault = flt;
    assign rd_valid = rd_ent.valid;
    assign rd_sel   = rd_ent.sel;
    assign rd_base  = rd_ent.base;
    assign rd_limit = rd_ent.limit;
    assign rd_attr  = rd_ent.attr;
endmodule

// File: rtl/seg_load_unit_chk.sv
`timescale 1ns/1ps
module seg_load_unit_chk
    import seg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ld_valid,
    input logic [SEG_W-1:0]  ld_seg,
    input logic              ld_ready,
    input logic              ld_done,
    input logic [1:0]        ld_fault,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    logic req_seen;

    always_ff @(posedge clk) begin
        if (rst)                       req_seen <= 1'b0;
        else if (ld_valid && ld_ready) req_seen <= 1'b0;
        else if (mem_req)              req_seen <= 1'b1;
    end

    a_r9_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ld_ready);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        ld_done |=> !ld_done);

    a_r9_fault_with_done: assert property (@(posedge clk) disable iff (rst)
        (ld_fault != 2'd0) |-> ld_done);

    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        ld_done |=> ld_ready);

    a_r9_ignore_seg: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_ready && (ld_seg >= SEG_W'(NUM_SEG))) |=> ld_ready);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r3_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_req && mem_ack) && mem_req) |-> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_STEP)));

    a_r2_limit_no_read: assert property (@(posedge clk) disable iff (rst)
        (ld_done && (ld_fault == 2'd1)) |-> !req_seen);
endmodule

bind seg_load_unit seg_load_unit_chk u_chk (.*);

// File: tb/seg_load_unit_tb.sv
`timescale 1ns/1ps
module seg_load_unit_tb;
    import seg_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we = 0, cfg_tbl = 0;
    logic [31:0] cfg_base = 0;
    logic [15:0] cfg_limit = 0;
    logic        ld_valid = 0;
    logic [2:0]  ld_seg = 0;
    logic [15:0] ld_sel = 0;
    logic        ld_ready, ld_done;
    logic [1:0]  ld_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 0;
    logic [31:0] mem_rdata = 0;
    logic [2:0]  rd_seg = 0;
    logic        rd_valid;
    logic [15:0] rd_sel;
    logic [31:0] rd_base;
    logic [19:0] rd_limit;
    logic [7:0]  rd_attr;

    always #4 clk = ~clk; // 125 MHz

    seg_load_unit u_dut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rd_cnt = 0, dly = 0;
    logic [31:0] a0, a1;

    logic [31:0] m_tbase [2];
    logic [15:0] m_tlim  [2];
    logic [15:0] m_sel  [6];
    logic        m_val  [6];
    logic [31:0] m_base [6];
    logic [19:0] m_lim  [6];
    logic [7:0]  m_attr [6];

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ {a[12:0], a[31:13]} ^ 32'hC3A50F1E;
    endfunction

    function automatic logic [1:0] exp_fault(logic [15:0] sel);
        logic [12:0] idx = sel[15:3];
        logic        ti  = sel[2];
        logic [31:0] hi;
        if (!ti && idx == 0) return 2'd0;
        if ({idx, 3'b111} > m_tlim[ti]) return 2'd1;
        hi = mem_word(m_tbase[ti] + {16'd0, idx, 3'b000} + 32'd4);
        if (!hi[27]) return 2'd2;
        if (!hi[20]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic int find_idx(logic ti, logic [1:0] want);
        for (int i = 1; i < 8192; i++) begin
            if (i * 8 + 7 > int'(m_tlim[ti])) break;
            if (exp_fault({13'(i), ti, 2'b00}) == want) return i;
        end
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory responder: random 0..2 cycle latency, one-cycle ack.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 0;
            dly = 0;
        end else if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req) begin
            if (dly == 0) begin
                mem_rdata = mem_word(mem_addr);
                mem_ack = 1;
                if (rd_cnt == 0) a0 = mem_addr; else a1 = mem_addr;
                rd_cnt++;
                dly = $urandom_range(0, 2);
            end else begin
                dly--;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cfg(input logic t, input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = t; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 0;
        m_tbase[t] = b; m_tlim[t] = l;
    endtask

    task automatic check_reg(input int s, input string tag);
        rd_seg = 3'(s);
        #1;
        chk(rd_valid == m_val[s], tag, "valid", rd_valid, m_val[s]);
        chk(rd_sel == m_sel[s], tag, "selector", rd_sel, m_sel[s]);
        chk(rd_base == m_base[s] && rd_limit == m_lim[s] && rd_attr == m_attr[s], tag,
            "base/limit/attr", {rd_base, rd_limit, rd_attr}, {m_base[s], m_lim[s], m_attr[s]});
    endtask

    task automatic do_load(input int s, input logic [15:0] sel);
        logic [1:0]  ef = exp_fault(sel);
        logic        is_null = !sel[2] && sel[15:3] == 0;
        logic [31:0] ea = m_tbase[sel[2]] + {16'd0, sel[15:3], 3'b000};
        int          ereads = (is_null || ef == 2'd1) ? 0 : 2;
        string       tag;
        bit          got = 0;
        logic [1:0]  f = 0;
        logic [31:0] hi;
        case (ef)
            2'd1: tag = "R2";
            2'd2: tag = "R5";
            2'd3: tag = "R6";
            default: tag = is_null ? "R7" : "R4";
        endcase
        @(negedge clk);
        for (int k = 0; k < 20 && !ld_ready; k++) @(negedge clk);
        rd_cnt = 0;
        ld_valid = 1; ld_seg = 3'(s); ld_sel = sel;
        @(negedge clk);
        ld_valid = 0;
        for (int k = 0; k < 60 && !got; k++) begin
            if (ld_done) begin got = 1; f = ld_fault; end
            else @(negedge clk);
        end
        chk(got, "R9", "done pulse seen", got, 1);
        chk(f == ef, tag, "fault code", f, ef);
        chk(rd_cnt == ereads, (ereads == 0) ? tag : "R3", "read count", rd_cnt, ereads);
        if (ereads == 2 && rd_cnt == 2) begin
            chk(a0 == ea, "R1", "low word address", a0, ea);
            chk(a1 == ea + 4, "R3", "high word address", a1, ea + 4);
        end
        if (ef == 2'd0) begin
            m_sel[s] = sel;
            if (is_null) begin
                m_val[s] = 0; m_base[s] = 0; m_lim[s] = 0; m_attr[s] = 0;
            end else begin
                hi = mem_word(ea + 4);
                m_val[s] = 1; m_base[s] = mem_word(ea);
                m_lim[s] = hi[19:0]; m_attr[s] = hi[27:20];
            end
        end
        @(negedge clk);
        check_reg(s, tag);
    endtask

    task automatic ignored_load(input logic [2:0] s, input logic [15:0] sel);
        bit bad = 0;
        @(negedge clk);
        rd_cnt = 0;
        ld_valid = 1; ld_seg = s; ld_sel = sel;
        @(negedge clk);
        ld_valid = 0;
        for (int k = 0; k < 6; k++) begin
            if (!ld_ready || ld_done) bad = 1;
            @(negedge clk);
        end
        chk(!bad && rd_cnt == 0, "R9", "register number 6/7 ignored", rd_cnt, 0);
        for (int r = 0; r < 6; r++) check_reg(r, "R9");
    endtask

    initial begin
        int idx;
        void'($urandom(32'd4242));
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = 0; m_val[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_attr[i] = 0;
        end
        m_tbase[0] = 0; m_tbase[1] = 0; m_tlim[0] = 0; m_tlim[1] = 0;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        chk(ld_ready, "R10", "ready after reset", ld_ready, 1);
        for (int r = 0; r < 6; r++) check_reg(r, "R10");

        // R8: reset limit 0, so local index 0 is beyond the limit
        do_load(2, {13'd0, 1'b1, 2'd1});
        chk(1, "R8", "reset limit exercised", 0, 0);

        cfg(0, 32'h0001_0000, 16'h03FF);
        cfg(1, 32'h0080_4000, 16'h01FF);

        // R7: global null and local index 0
        do_load(0, {13'd0, 1'b0, 2'd3});
        do_load(1, {13'd0, 1'b1, 2'd2});

        // R1/R4/R5/R6: directed descriptor kinds in each table
        for (int t = 0; t < 2; t++)
            for (int w = 0; w < 4; w++) begin
                if (w == 1) continue;
                idx = find_idx(t[0], 2'(w));
                chk(idx != 0, "R4", "directed index found", idx, 1);
                if (idx != 0) do_load((t * 3 + w) % 6, {13'(idx), t[0], 2'(w)});
            end

        // R2: limit boundaries
        cfg(1, 32'h0020_0000, 16'h00FF); // last index 31
        do_load(3, {13'd31, 1'b1, 2'd0});
        do_load(3, {13'd32, 1'b1, 2'd0});
        cfg(1, 32'h0020_0000, 16'h00FE); // index 31 now overruns by one byte
        do_load(4, {13'd31, 1'b1, 2'd0});
        cfg(0, 32'hFFF0_0000, 16'hFFFF);
        do_load(5, {13'd8191, 1'b0, 2'd1});

        // R9: ignored register numbers
        ignored_load(3'd6, {13'd5, 1'b0, 2'd0});
        ignored_load(3'd7, {13'd9, 1'b1, 2'd0});

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic ti;
            int   span;
            if (n % 50 == 0) begin
                cfg($urandom_range(0, 1), $urandom & 32'hFFFF_FFF8, 16'($urandom_range(0, 4095)));
            end
            ti = $urandom_range(0, 1);
            span = (int'(m_tlim[ti]) + 1) / 8 + 3;
            if ($urandom_range(0, 29) == 0)
                ignored_load(3'($urandom_range(6, 7)), 16'($urandom));
            else
                do_load($urandom_range(0, 5),
                        {13'($urandom_range(0, span)), ti, 2'($urandom_range(0, 3))});
        end

        for (int r = 0; r < 6; r++) check_reg(r, "R4");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule